// File: doc/BRIEF.md
# USB Token Packet Encoder

This block turns a request for a USB full-speed token or handshake into the byte stream that a UTMI-style transmitter expects. A caller presents a 4-bit packet identifier and an 11-bit field and pulses a start strobe. The block adds the check nibble to the identifier and computes the CRC5 over the field. It then sends one or three bytes, each held on the data lines until the transmitter takes it. NRZI coding, bit stuffing and serialisation belong to the transmitter downstream and are not done here.

The 11-bit field is used the same way for every token kind. For OUT, IN and SETUP it holds the 7-bit function address in bits [6:0] and the 4-bit endpoint in bits [10:7]. For SOF it holds the 11-bit frame number. A busy flag covers the whole packet, and a one-cycle done pulse marks its end.

Top module: `usb_tok_enc`

## Requirements
- R1: After reset, `tx_valid_o`, `busy_o` and `done_o` are low.
- R2: A start while idle captures `pid_i` and `field_i`. On the next cycle `tx_valid_o` and `busy_o` are high and `tx_data_o` is `{~pid, pid}`, with the complement in bits [7:4]. Input changes after that capture have no effect on the packet.
- R3: A packet identifier whose low two bits are not `10` is a token and is sent as three bytes: the identifier byte, then `field[7:0]`, then `{crc5[4:0], field[10:8]}`.
- R4: The CRC5 uses the polynomial x^5+x^2+1 and starts from all ones. It shifts in the field bit 0 first, and the final remainder is complemented. Its highest-order bit is the first one sent, at byte bit 3. For SETUP to address 0, endpoint 0, the bytes are 0x2D, 0x00, 0x10.
- R5: A packet identifier whose low two bits are `10` is a handshake and is sent as a single byte. ACK (0010) gives 0xD2, NAK (1010) gives 0x5A and STALL (1110) gives 0x1E.
- R6: While `tx_valid_o` is high and `tx_ready_i` is low, the byte on `tx_data_o` and `tx_valid_o` stay unchanged. A byte is accepted on a clock edge where both are high.
- R7: In the cycle after the last byte is accepted, `tx_valid_o` and `busy_o` are low and `done_o` is high for exactly one cycle.
- R8: A start strobe while busy is ignored. The packet in flight keeps its bytes, and no second packet follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| pid_i | input | 4 | Packet identifier |
| field_i | input | 11 | Endpoint and address, or frame number |
| tx_data_o | output | 8 | Byte presented to the transmitter |
| tx_valid_o | output | 1 | Byte on `tx_data_o` is valid |
| tx_ready_i | input | 1 | Transmitter takes the current byte |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions check the handshake rules on every cycle:
- a stalled byte stays stable;
- the first byte of every packet carries a correct check nibble;
- busy falling always comes with a single-cycle done;
- a start during a packet never disturbs the byte on the lines.

Only the bench's scenarios can show that the byte count fits the identifier class and that the field bits sit in the right positions. The same holds for the CRC5 value, which the bench compares against known vectors, and for no second packet following an ignored start.

// File: rtl/usb_tok_pkg.sv
package usb_tok_pkg;
    localparam int PID_W     = 4;
    localparam int FIELD_W   = 11;
    localparam int CRC_W     = 5;
    localparam int BYTE_W    = 8;
    localparam int NBYTES    = 3;
    localparam int IDX_W     = $clog2(NBYTES);
    localparam int CLASS_W   = 2;

    // identifier class code marking a one-byte handshake
    localparam logic [CLASS_W-1:0] CLASS_HSK = 2'b10;
    // generator polynomial x^5 + x^2 + 1 without the top term
    localparam logic [CRC_W-1:0]   CRC_POLY  = 5'b00101;

    typedef logic [BYTE_W-1:0]             byte_t;
    typedef logic [NBYTES-1:0][BYTE_W-1:0] pkt_t;

    typedef enum logic {
        ST_IDLE,
        ST_SEND
    } seq_st_e;

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] last;
        pkt_t             pkt;
        logic             done;
    } seq_t;
endpackage

// File: rtl/usb_tok_crc5.sv
module usb_tok_crc5
    import usb_tok_pkg::*;
#(
    parameter int               DATA_W = FIELD_W,
    parameter int               REM_W  = CRC_W,
    parameter logic [REM_W-1:0] POLY   = CRC_POLY
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [REM_W-1:0]  crc_o
);
    logic [REM_W-1:0] rem;

    always_comb begin
        logic [REM_W-1:0] r;
        logic             fb;
        r = '1;
        for (int i = 0; i < DATA_W; i++) begin
            fb = data_i[i] ^ r[REM_W-1];
            r  = {r[REM_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
        rem = r;
    end

    // the highest-order remainder bit goes out first, so it lands in bit 0
    for (genvar k = 0; k < REM_W; k++) begin : g_rev
        assign crc_o[k] = ~rem[REM_W-1-k];
    end
endmodule

// File: rtl/usb_tok_pack.sv
module usb_tok_pack
    import usb_tok_pkg::*;
#(
    parameter int P_W = PID_W,
    parameter int F_W = FIELD_W,
    parameter int C_W = CRC_W,
    parameter int B_W = BYTE_W,
    parameter int N_B = NBYTES,
    parameter int I_W = IDX_W
) (
    input  logic [P_W-1:0]          pid_i,
    input  logic [F_W-1:0]          field_i,
    input  logic [C_W-1:0]          crc_i,
    output logic [N_B-1:0][B_W-1:0] bytes_o,
    output logic [I_W-1:0]          last_o
);
    localparam int HI_W = F_W - B_W;

    logic is_hsk;

    assign is_hsk = (pid_i[CLASS_W-1:0] == CLASS_HSK);

    always_comb begin
        bytes_o[0] = {~pid_i, pid_i};
        bytes_o[1] = field_i[B_W-1:0];
        bytes_o[2] = {crc_i, field_i[F_W-1:F_W-HI_W]};
        last_o     = is_hsk ? '0 : I_W'(N_B - 1);
    end
endmodule

// File: rtl/usb_tok_tx_seq.sv
module usb_tok_tx_seq
    import usb_tok_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  pkt_t             pkt_i,
    input  logic [IDX_W-1:0] last_i,
    output byte_t            tx_data_o,
    output logic             tx_valid_o,
    input  logic             tx_ready_i,
    output logic             busy_o,
    output logic             done_o
);
    seq_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_SEND;
                    d.idx  = '0;
                    d.last = last_i;
                    d.pkt  = pkt_i;
                end
            end
            ST_SEND: begin
                if (tx_ready_i) begin
                    if (q.idx == q.last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, idx: '0, last: '0, pkt: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign tx_valid_o = (q.st == ST_SEND);
    assign busy_o     = (q.st == ST_SEND);
    assign tx_data_o  = q.pkt[q.idx];
    assign done_o     = q.done;
endmodule

// File: rtl/usb_tok_enc.sv
module usb_tok_enc
    import usb_tok_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PID_W-1:0]   pid_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic [BYTE_W-1:0]  tx_data_o,
    output logic               tx_valid_o,
    input  logic               tx_ready_i,
    output logic               busy_o,
    output logic               done_o
);
    logic [CRC_W-1:0] crc;
    pkt_t             pkt;
    logic [IDX_W-1:0] last;

    usb_tok_crc5 i_crc (
        .data_i (field_i),
        .crc_o  (crc)
    );

    usb_tok_pack i_pack (
        .pid_i   (pid_i),
        .field_i (field_i),
        .crc_i   (crc),
        .bytes_o (pkt),
        .last_o  (last)
    );

    usb_tok_tx_seq i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .pkt_i      (pkt),
        .last_i     (last),
        .tx_data_o  (tx_data_o),
        .tx_valid_o (tx_valid_o),
        .tx_ready_i (tx_ready_i),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );
endmodule

// File: rtl/usb_tok_enc_chk.sv
module usb_tok_enc_chk
    import usb_tok_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [PID_W-1:0]   pid_i,
    input logic [FIELD_W-1:0] field_i,
    input logic [BYTE_W-1:0]  tx_data_o,
    input logic               tx_valid_o,
    input logic               tx_ready_i,
    input logic               busy_o,
    input logic               done_o
);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

    // R2
    pid_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> (tx_data_o[7:4] == ~tx_data_o[3:0]));

    // R7
    end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o && !tx_valid_o);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && start_i && !(tx_valid_o && tx_ready_i) |=> busy_o && $stable(tx_data_o));
endmodule

bind usb_tok_enc usb_tok_enc_chk i_chk (.*);

// File: tb/test_usb_tok_enc.sv
module test_usb_tok_enc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  pid_i = '0;
    logic [10:0] field_i = '0;
    logic [7:0]  tx_data_o;
    logic        tx_valid_o;
    logic        tx_ready_i = 1'b0;
    logic        busy_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    usb_tok_enc i_usb_tok_enc (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] ref_crc(input logic [10:0] f);
        logic [4:0] c = 5'h1f;
        for (int i = 0; i < 11; i++) begin
            logic fb = f[i] ^ c[4];
            c = {c[3:0], 1'b0};
            if (fb) c = c ^ 5'b00101;
        end
        return {~c[0], ~c[1], ~c[2], ~c[3], ~c[4]};
    endfunction

    // sends one packet; stall_en inserts ready-low cycles, inject pulses start mid-packet
    task automatic run_pkt(input logic [3:0] pid, input logic [10:0] fld,
                           input bit stall_en, input bit inject, input string tag);
        logic [7:0] exp [3];
        logic [7:0] got [3];
        logic [7:0] held;
        int en, n, cyc;
        bit stall;
        en     = (pid[1:0] == 2'b10) ? 1 : 3;
        exp[0] = {~pid, pid};
        exp[1] = fld[7:0];
        exp[2] = {ref_crc(fld), fld[10:8]};
        @(negedge clk);
        start_i = 1'b1; pid_i = pid; field_i = fld; tx_ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; pid_i = ~pid; field_i = ~fld;
        chk(tx_valid_o === 1'b1 && busy_o === 1'b1, {"R2 valid/busy ", tag}, {tx_valid_o, busy_o}, 2'b11);
        chk(tx_data_o === exp[0], {"R2 first byte ", tag}, tx_data_o, exp[0]);
        n = 0; cyc = 0;
        while (n < en && cyc < 60) begin
            stall = stall_en && (cyc % 3 != 2);
            if (inject && cyc == 1) begin
                start_i = 1'b1; pid_i = 4'b0010; field_i = 11'h555;
            end else begin
                start_i = 1'b0;
            end
            tx_ready_i = !stall;
            held = tx_data_o;
            if (!stall) begin
                got[n] = tx_valid_o ? tx_data_o : 8'hxx;
                n++;
            end
            @(negedge clk);
            cyc++;
            if (stall) chk(tx_valid_o === 1'b1 && tx_data_o === held, {"R6 hold ", tag}, tx_data_o, held);
        end
        start_i = 1'b0; tx_ready_i = 1'b0;
        chk(tx_valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b1, {"R7 end ", tag},
            {tx_valid_o, busy_o, done_o}, 3'b001);
        for (int i = 0; i < en; i++)
            chk(got[i] === exp[i], {(en == 1) ? "R5 byte " : (i == 2 ? "R4 crc byte " : "R3 byte "), tag}, got[i], exp[i]);
        @(negedge clk);
        chk(done_o === 1'b0, {"R7 done pulse ", tag}, done_o, 1'b0);
        if (inject) begin
            for (int i = 0; i < 3; i++) begin
                chk(tx_valid_o === 1'b0 && busy_o === 1'b0, {"R8 no second packet ", tag}, tx_valid_o, 1'b0);
                @(negedge clk);
            end
        end
    endtask

    // fixed vector: SETUP to address 0 endpoint 0
    task automatic t_setup_known;
        logic [7:0] b [3];
        @(negedge clk);
        start_i = 1'b1; pid_i = 4'b1101; field_i = 11'h000; tx_ready_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            b[i] = tx_data_o;
            @(negedge clk);
        end
        tx_ready_i = 1'b0;
        chk(b[0] === 8'h2D, "R2 setup pid byte", b[0], 8'h2D);
        chk(b[1] === 8'h00, "R3 setup field byte", b[1], 8'h00);
        chk(b[2] === 8'h10, "R4 setup crc byte", b[2], 8'h10);
        chk(done_o === 1'b1, "R7 setup done", done_o, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_handshakes;
        run_pkt(4'b0010, 11'h7ff, 1'b0, 1'b0, "ack");
        run_pkt(4'b1010, 11'h123, 1'b1, 1'b0, "nak");
        run_pkt(4'b1110, 11'h000, 1'b0, 1'b0, "stall");
        chk({~4'b0010, 4'b0010} == 8'hD2, "R5 ack code", {~4'b0010, 4'b0010}, 8'hD2);
    endtask

    task automatic t_tokens;
        run_pkt(4'b0001, {4'h1, 7'h12}, 1'b1, 1'b0, "out");
        run_pkt(4'b1001, {4'hF, 7'h7F}, 1'b0, 1'b0, "in");
        run_pkt(4'b1101, {4'hA, 7'h3A}, 1'b1, 1'b0, "setup");
        run_pkt(4'b0101, 11'h000, 1'b0, 1'b0, "sof0");
        run_pkt(4'b0101, 11'h7FF, 1'b1, 1'b0, "sofmax");
        run_pkt(4'b0101, 11'h2A5, 1'b0, 1'b0, "sofmid");
    endtask

    task automatic t_ignore_start;
        run_pkt(4'b1001, {4'h5, 7'h2C}, 1'b1, 1'b1, "busy start");
    endtask

    initial begin
        #200us;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        repeat (2) @(negedge clk);
        chk(tx_valid_o === 1'b0 && busy_o === 1'b0 && done_o === 1'b0, "R1 reset state",
            {tx_valid_o, busy_o, done_o}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_valid_o === 1'b0 && busy_o === 1'b0, "R1 after release", {tx_valid_o, busy_o}, 2'b00);
        t_setup_known();
        t_handshakes();
        t_tokens();
        t_ignore_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule